// File: doc/BRIEF.md
# Debug Snapshot Bus-Master Sequencer

This block is a small bus master that, when given a start pulse, takes a safe snapshot of a processor's sampled program counter and its execution context from a debug register slave. It first opens the slave's OS lock and keeps a copy of the power-request control word. It then asks for core power, polls the power status with a bounded number of spaced attempts, and pins power on with a no-power-down request. Before touching the sample registers it checks that access is allowed.

When access is allowed it reads the program-counter sample. A sample of all ones means sampling is currently blocked, and the remaining reads are skipped. Otherwise the upper PC word, the context identifier and the VM/state word are read, each only when its enable input is set. Every path ends by writing the saved control word back, and then a one-cycle done pulse is given. The captured words, a valid flag and three separate failure flags stay on the outputs until the next start.

The bus carries one access at a time. The master holds request, write flag, address and write data. An access completes on a clock edge where both `bus_req` and `bus_rdy` are high. Read data is taken on that same edge.

Top module: `dbg_snap_seq`

## Requirements
- R1: After reset `bus_req`, `busy`, `done`, `snap_valid` and all three failure flags are low, and all captured words and `pwr_status` are zero.
- R2: A sequence opens with a write of zero to address 0x300, followed by a read of the control word at 0x310. That read value is kept as the saved control word.
- R3: A power-up step reads 0x310 and writes back the read value with bit 3 set. It then reads status at 0x314 until bit 0 is set. Between two status reads there are POLL_GAP idle cycles.
- R4: If POLL_MAX consecutive status reads within one power-up step all show bit 0 clear, `flag_timeout` is set. The next and last access is then the restore write.
- R5: Once power is seen, the block reads 0x310 and writes back the read value with bits 3 and 0 set, then reads 0x314 again. If bit 0 is now clear, the whole power-up step of R3 is repeated with a fresh attempt budget.
- R6: If that last status read has bit 0 set and bit 6 set, `flag_noperm` is set and no sample register is read. `pwr_status` holds the last status word read.
- R7: The PC sample is read at 0x0A0. If it equals 0xFFFFFFFF, `flag_prohib` is set, `snap_valid` stays low and no optional register is read.
- R8: For a valid sample, the optional reads follow in this order: upper PC at 0x0AC (if `en_pc_hi`), context ID at 0x0A4 (if `en_ctx`), VM/state at 0x0A8 (if `en_vm`). Words not read are zero after the sequence. `snap_valid` is set.
- R9: On every exit path the last bus access is a write of the saved control word to 0x310. `done` then pulses for exactly one cycle with no request pending. Exactly one of `snap_valid`, `flag_timeout`, `flag_noperm`, `flag_prohib` is high at `done`.
- R10: While `bus_req` is high and `bus_rdy` is low, request, write flag, address and write data do not change.
- R11: A start pulse while `busy` is high is ignored. It causes no second sequence and no second done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted when idle |
| en_pc_hi | input | 1 | Enable the upper PC read |
| en_ctx | input | 1 | Enable the context ID read |
| en_vm | input | 1 | Enable the VM/state read |
| bus_req | output | 1 | Access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | 12 | Register byte address |
| bus_wdata | output | 32 | Write data |
| bus_rdy | input | 1 | Slave completes the access this cycle |
| bus_rdata | input | 32 | Read data, valid with bus_rdy |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| snap_valid | output | 1 | Sample captured and usable |
| flag_timeout | output | 1 | Power never came up |
| flag_noperm | output | 1 | Access refused by status |
| flag_prohib | output | 1 | Sample read as all ones |
| pc_lo | output | 32 | Lower PC sample |
| pc_hi | output | 32 | Upper PC sample |
| ctx_id | output | 32 | Context identifier |
| vm_state | output | 32 | VM/state word |
| pwr_status | output | 32 | Last power status word read |

## Verification
The hardest case to reach from the ports is power dropping right after the no-power-down write. Only a slave whose status answers change from one read to the next can produce it. The bench model therefore plays out a per-test script of status words, one per status read. This lets a test arrange, in turn, slow power-up, no power at all, a drop after pinning, and the lock bit. A ready signal that stalls on every other cycle exercises the hold rule, and spaced poll reads are checked from logged transfer cycles.

// File: rtl/dbg_snap_pkg.sv
package dbg_snap_pkg;

    localparam int AW = 12;
    localparam int DW = 32;

    localparam logic [AW-1:0] A_OSLOCK  = 12'h300;
    localparam logic [AW-1:0] A_PWRCTL  = 12'h310;
    localparam logic [AW-1:0] A_PWRSTAT = 12'h314;
    localparam logic [AW-1:0] A_PCLO    = 12'h0A0;
    localparam logic [AW-1:0] A_CTX     = 12'h0A4;
    localparam logic [AW-1:0] A_VM      = 12'h0A8;
    localparam logic [AW-1:0] A_PCHI    = 12'h0AC;

    localparam int CTL_UP_BIT   = 3;
    localparam int CTL_KEEP_BIT = 0;
    localparam int ST_PU_BIT    = 0;
    localparam int ST_LOCK_BIT  = 6;

    localparam logic [DW-1:0] PC_BLOCKED = '1;

    typedef enum logic [3:0] {
        S_IDLE, S_UNLOCK, S_SAVE, S_PU_RD, S_PU_WR, S_POLL_RD, S_POLL_WAIT,
        S_NPD_RD, S_NPD_WR, S_STAT_RD, S_PC_RD, S_HI_RD, S_CTX_RD, S_VM_RD,
        S_RESTORE, S_DONE
    } seq_state_e;

    typedef enum logic [2:0] {
        CAP_NONE = 3'd0,
        CAP_PCLO = 3'd1,
        CAP_PCHI = 3'd2,
        CAP_CTX  = 3'd3,
        CAP_VM   = 3'd4
    } cap_sel_e;

    typedef struct packed {
        logic want_hi;
        logic want_ctx;
        logic want_vm;
    } opt_cfg_t;

    typedef struct packed {
        logic timeout;
        logic noperm;
        logic prohib;
        logic valid;
    } snap_flags_t;

    // bus request as presented by one sequencer state
    typedef struct packed {
        logic          req;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } bus_cmd_t;

    function automatic logic access_ok(input logic [DW-1:0] st);
        return st[ST_PU_BIT] && !st[ST_LOCK_BIT];
    endfunction

    // first optional read still to do after the given state
    function automatic seq_state_e next_opt(input seq_state_e cur, input opt_cfg_t c);
        seq_state_e n;
        n = S_RESTORE;
        if (c.want_vm && cur != S_VM_RD) n = S_VM_RD;
        if (c.want_ctx && (cur == S_PC_RD || cur == S_HI_RD)) n = S_CTX_RD;
        if (c.want_hi && cur == S_PC_RD) n = S_HI_RD;
        return n;
    endfunction

endpackage

// File: rtl/dbg_snap_timer.sv
module dbg_snap_timer #(
    parameter int POLL_GAP = 1000,
    parameter int POLL_MAX = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic att_clr,
    input  logic gap_load,
    input  logic att_bump,
    output logic gap_zero,
    output logic last_try
);
    localparam int GW = $clog2(POLL_GAP + 1);
    localparam int TW = $clog2(POLL_MAX + 1);

    logic [GW-1:0] gap_q;
    logic [TW-1:0] att_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= '0;
        end else if (gap_load) begin
            gap_q <= GW'(POLL_GAP - 1);
        end else if (gap_q != '0) begin
            gap_q <= gap_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || att_clr) begin
            att_q <= '0;
        end else if (att_bump) begin
            att_q <= att_q + 1'b1;
        end
    end

    assign gap_zero = (gap_q == '0);
    assign last_try = (att_q == TW'(POLL_MAX - 1));
endmodule

// File: rtl/dbg_snap_capture.sv
module dbg_snap_capture
    import dbg_snap_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  cap_sel_e      ld,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] pc_lo,
    output logic [DW-1:0] pc_hi,
    output logic [DW-1:0] ctx_id,
    output logic [DW-1:0] vm_state
);
    localparam int NSLOT = 4;

    logic [NSLOT-1:0][DW-1:0] slot_q;

    always_ff @(posedge clk) begin
        for (int g = 0; g < NSLOT; g++) begin
            if (rst || clr) begin
                slot_q[g] <= '0;
            end else if (ld == cap_sel_e'(g + 1)) begin
                slot_q[g] <= din;
            end
        end
    end

    assign pc_lo    = slot_q[0];
    assign pc_hi    = slot_q[1];
    assign ctx_id   = slot_q[2];
    assign vm_state = slot_q[3];
endmodule

// File: rtl/dbg_snap_seq.sv
module dbg_snap_seq
    import dbg_snap_pkg::*;
#(
    parameter int POLL_GAP = 1000,
    parameter int POLL_MAX = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          en_pc_hi,
    input  logic          en_ctx,
    input  logic          en_vm,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_rdy,
    input  logic [DW-1:0] bus_rdata,
    output logic          busy,
    output logic          done,
    output logic          snap_valid,
    output logic          flag_timeout,
    output logic          flag_noperm,
    output logic          flag_prohib,
    output logic [DW-1:0] pc_lo,
    output logic [DW-1:0] pc_hi,
    output logic [DW-1:0] ctx_id,
    output logic [DW-1:0] vm_state,
    output logic [DW-1:0] pwr_status
);
    localparam logic [DW-1:0] UP_MASK   = DW'(1) << CTL_UP_BIT;
    localparam logic [DW-1:0] KEEP_MASK = UP_MASK | (DW'(1) << CTL_KEEP_BIT);

    seq_state_e  st_q, st_d;
    logic [DW-1:0] saved_q, rmw_q, stat_q;
    opt_cfg_t    cfg_q;
    snap_flags_t flg_q, flg_set;
    bus_cmd_t    cmd;
    cap_sel_e    cap_ld;
    logic        xfer, go;
    logic        tmr_clr, tmr_load, tmr_bump, gap_zero, last_try;

    assign go   = (st_q == S_IDLE) && start;
    assign xfer = cmd.req && bus_rdy;

    // bus command decoded from the current state
    always_comb begin
        cmd = '0;
        case (st_q)
            S_UNLOCK:  cmd = '{req: 1'b1, we: 1'b1, addr: A_OSLOCK, wdata: '0};
            S_SAVE,
            S_PU_RD,
            S_NPD_RD:  cmd = '{req: 1'b1, we: 1'b0, addr: A_PWRCTL, wdata: '0};
            S_PU_WR:   cmd = '{req: 1'b1, we: 1'b1, addr: A_PWRCTL, wdata: rmw_q | UP_MASK};
            S_NPD_WR:  cmd = '{req: 1'b1, we: 1'b1, addr: A_PWRCTL, wdata: rmw_q | KEEP_MASK};
            S_POLL_RD,
            S_STAT_RD: cmd = '{req: 1'b1, we: 1'b0, addr: A_PWRSTAT, wdata: '0};
            S_PC_RD:   cmd = '{req: 1'b1, we: 1'b0, addr: A_PCLO, wdata: '0};
            S_HI_RD:   cmd = '{req: 1'b1, we: 1'b0, addr: A_PCHI, wdata: '0};
            S_CTX_RD:  cmd = '{req: 1'b1, we: 1'b0, addr: A_CTX, wdata: '0};
            S_VM_RD:   cmd = '{req: 1'b1, we: 1'b0, addr: A_VM, wdata: '0};
            S_RESTORE: cmd = '{req: 1'b1, we: 1'b1, addr: A_PWRCTL, wdata: saved_q};
            default:   cmd = '0;
        endcase
    end

    always_comb begin
        st_d     = st_q;
        tmr_clr  = 1'b0;
        tmr_load = 1'b0;
        tmr_bump = 1'b0;
        cap_ld   = CAP_NONE;
        flg_set  = '0;
        case (st_q)
            S_IDLE:   if (start) st_d = S_UNLOCK;
            S_UNLOCK: if (xfer) st_d = S_SAVE;
            S_SAVE:   if (xfer) st_d = S_PU_RD;
            S_PU_RD:  if (xfer) st_d = S_PU_WR;
            S_PU_WR: begin
                if (xfer) begin
                    st_d    = S_POLL_RD;
                    tmr_clr = 1'b1;
                end
            end
            S_POLL_RD: begin
                if (xfer) begin
                    if (bus_rdata[ST_PU_BIT]) begin
                        st_d = S_NPD_RD;
                    end else if (last_try) begin
                        st_d = S_RESTORE;
                        flg_set.timeout = 1'b1;
                    end else begin
                        st_d     = S_POLL_WAIT;
                        tmr_load = 1'b1;
                        tmr_bump = 1'b1;
                    end
                end
            end
            S_POLL_WAIT: if (gap_zero) st_d = S_POLL_RD;
            S_NPD_RD:    if (xfer) st_d = S_NPD_WR;
            S_NPD_WR:    if (xfer) st_d = S_STAT_RD;
            S_STAT_RD: begin
                if (xfer) begin
                    if (!bus_rdata[ST_PU_BIT]) begin
                        st_d = S_PU_RD;
                    end else if (!access_ok(bus_rdata)) begin
                        st_d = S_RESTORE;
                        flg_set.noperm = 1'b1;
                    end else begin
                        st_d = S_PC_RD;
                    end
                end
            end
            S_PC_RD: begin
                if (xfer) begin
                    cap_ld = CAP_PCLO;
                    if (bus_rdata == PC_BLOCKED) begin
                        st_d = S_RESTORE;
                        flg_set.prohib = 1'b1;
                    end else begin
                        st_d = next_opt(S_PC_RD, cfg_q);
                        flg_set.valid = 1'b1;
                    end
                end
            end
            S_HI_RD: begin
                if (xfer) begin
                    cap_ld = CAP_PCHI;
                    st_d   = next_opt(S_HI_RD, cfg_q);
                end
            end
            S_CTX_RD: begin
                if (xfer) begin
                    cap_ld = CAP_CTX;
                    st_d   = next_opt(S_CTX_RD, cfg_q);
                end
            end
            S_VM_RD: begin
                if (xfer) begin
                    cap_ld = CAP_VM;
                    st_d   = S_RESTORE;
                end
            end
            S_RESTORE: if (xfer) st_d = S_DONE;
            S_DONE:    st_d = S_IDLE;
            default:   st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= S_IDLE;
            saved_q <= '0;
            rmw_q   <= '0;
            stat_q  <= '0;
            cfg_q   <= '0;
            flg_q   <= '0;
        end else begin
            st_q <= st_d;
            if (go) begin
                cfg_q  <= '{want_hi: en_pc_hi, want_ctx: en_ctx, want_vm: en_vm};
                flg_q  <= '0;
                stat_q <= '0;
            end else begin
                flg_q <= flg_q | flg_set;
            end
            if (xfer && st_q == S_SAVE) saved_q <= bus_rdata;
            if (xfer && (st_q == S_PU_RD || st_q == S_NPD_RD)) rmw_q <= bus_rdata;
            if (xfer && (st_q == S_POLL_RD || st_q == S_STAT_RD)) stat_q <= bus_rdata;
        end
    end

    dbg_snap_timer #(
        .POLL_GAP (POLL_GAP),
        .POLL_MAX (POLL_MAX)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .att_clr  (tmr_clr),
        .gap_load (tmr_load),
        .att_bump (tmr_bump),
        .gap_zero (gap_zero),
        .last_try (last_try)
    );

    dbg_snap_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .clr      (go),
        .ld       (cap_ld),
        .din      (bus_rdata),
        .pc_lo    (pc_lo),
        .pc_hi    (pc_hi),
        .ctx_id   (ctx_id),
        .vm_state (vm_state)
    );

    assign bus_req      = cmd.req;
    assign bus_we       = cmd.we;
    assign bus_addr     = cmd.addr;
    assign bus_wdata    = cmd.wdata;
    assign busy         = (st_q != S_IDLE);
    assign done         = (st_q == S_DONE);
    assign snap_valid   = flg_q.valid;
    assign flag_timeout = flg_q.timeout;
    assign flag_noperm  = flg_q.noperm;
    assign flag_prohib  = flg_q.prohib;
    assign pwr_status   = stat_q;
endmodule

// File: rtl/dbg_snap_chk.sv
module dbg_snap_chk
    import dbg_snap_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          bus_req,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          bus_rdy,
    input logic [DW-1:0] bus_rdata,
    input logic          done,
    input logic          snap_valid,
    input logic          flag_timeout,
    input logic          flag_noperm,
    input logic          flag_prohib,
    input logic [DW-1:0] pc_lo
);
    logic          after_unlock_q;
    logic [DW-1:0] saved_seen_q;
    logic [AW-1:0] last_wa_q;
    logic [DW-1:0] last_wd_q;
    logic          hs;

    assign hs = bus_req && bus_rdy;

    always_ff @(posedge clk) begin
        if (rst) begin
            after_unlock_q <= 1'b0;
            saved_seen_q   <= '0;
            last_wa_q      <= '0;
            last_wd_q      <= '0;
        end else if (hs) begin
            if (bus_we) begin
                last_wa_q <= bus_addr;
                last_wd_q <= bus_wdata;
            end
            if (bus_we && bus_addr == A_OSLOCK) begin
                after_unlock_q <= 1'b1;
            end else if (!bus_we && bus_addr == A_PWRCTL && after_unlock_q) begin
                saved_seen_q   <= bus_rdata;
                after_unlock_q <= 1'b0;
            end
        end
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_rdy) |=> (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !bus_req);

    // R9
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($countones({snap_valid, flag_timeout, flag_noperm, flag_prohib}) == 1));

    // R9
    restore_last_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (last_wa_q == A_PWRCTL && last_wd_q == saved_seen_q));

    // R7
    valid_pc_chk: assert property (@(posedge clk) disable iff (rst)
        (done && snap_valid) |-> (pc_lo != PC_BLOCKED));
endmodule

bind dbg_snap_seq dbg_snap_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_req      (bus_req),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdy      (bus_rdy),
    .bus_rdata    (bus_rdata),
    .done         (done),
    .snap_valid   (snap_valid),
    .flag_timeout (flag_timeout),
    .flag_noperm  (flag_noperm),
    .flag_prohib  (flag_prohib),
    .pc_lo        (pc_lo)
);

// File: tb/dbg_snap_seq_bench.sv
module dbg_snap_seq_bench;
    localparam int GAP = 4;
    localparam int MAXT = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic en_pc_hi = 1'b0, en_ctx = 1'b0, en_vm = 1'b0;
    logic bus_req, bus_we, bus_rdy, busy, done;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic snap_valid, flag_timeout, flag_noperm, flag_prohib;
    logic [31:0] pc_lo, pc_hi, ctx_id, vm_state, pwr_status;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dbg_snap_seq #(.POLL_GAP(GAP), .POLL_MAX(MAXT)) u_dbg_snap_seq (
        .clk(clk), .rst(rst), .start(start),
        .en_pc_hi(en_pc_hi), .en_ctx(en_ctx), .en_vm(en_vm),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdy(bus_rdy), .bus_rdata(bus_rdata),
        .busy(busy), .done(done), .snap_valid(snap_valid),
        .flag_timeout(flag_timeout), .flag_noperm(flag_noperm), .flag_prohib(flag_prohib),
        .pc_lo(pc_lo), .pc_hi(pc_hi), .ctx_id(ctx_id), .vm_state(vm_state),
        .pwr_status(pwr_status)
    );

    // ---------------- slave model ----------------
    logic        slow = 1'b0;
    logic        tb_clear = 1'b0;
    logic        ws_q = 1'b0;
    logic [31:0] ctl_init = '0;
    logic [31:0] ctl_reg = '0;
    logic [31:0] stat_seq [0:15];
    int          stat_idx = 0;
    logic [31:0] v_pc = '0, v_hi = '0, v_ctx = '0, v_vm = '0;

    logic        log_we   [0:63];
    logic [11:0] log_addr [0:63];
    logic [31:0] log_data [0:63];
    int          log_cyc  [0:63];
    int          log_n = 0;
    int          cyc = 0;
    int          n_done = 0;

    assign bus_rdy = bus_req && (!slow || ws_q);

    always_comb begin
        case (bus_addr)
            12'h310: bus_rdata = ctl_reg;
            12'h314: bus_rdata = stat_seq[stat_idx];
            12'h0A0: bus_rdata = v_pc;
            12'h0AC: bus_rdata = v_hi;
            12'h0A4: bus_rdata = v_ctx;
            12'h0A8: bus_rdata = v_vm;
            default: bus_rdata = 32'h0;
        endcase
    end

    always @(posedge clk) begin
        cyc  <= cyc + 1;
        ws_q <= ~ws_q;
        if (tb_clear) begin
            log_n    <= 0;
            stat_idx <= 0;
            ctl_reg  <= ctl_init;
            n_done   <= 0;
        end else begin
            if (done) n_done <= n_done + 1;
            if (bus_req && bus_rdy) begin
                if (log_n < 64) begin
                    log_we[log_n]   <= bus_we;
                    log_addr[log_n] <= bus_addr;
                    log_data[log_n] <= bus_we ? bus_wdata : bus_rdata;
                    log_cyc[log_n]  <= cyc;
                    log_n <= log_n + 1;
                end
                if (bus_we && bus_addr == 12'h310) ctl_reg <= bus_wdata;
                if (!bus_we && bus_addr == 12'h314 && stat_idx < 15) stat_idx <= stat_idx + 1;
            end
        end
    end

    // ---------------- expected sequence ----------------
    logic        e_we   [0:63];
    logic [11:0] e_addr [0:63];
    logic [31:0] e_data [0:63];
    int          e_n = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ex(input logic we, input logic [11:0] a, input logic [31:0] d);
        e_we[e_n] = we; e_addr[e_n] = a; e_data[e_n] = d; e_n++;
    endtask

    task automatic cmp_log(input string req);
        chk(log_n == e_n, {req, " access count"}, log_n, e_n);
        for (int i = 0; i < e_n && i < log_n; i++) begin
            chk(log_we[i] == e_we[i] && log_addr[i] == e_addr[i] &&
                (!e_we[i] || log_data[i] == e_data[i]),
                {req, " access"}, {log_we[i], 7'd0, log_addr[i], log_data[i][11:0]},
                {e_we[i], 7'd0, e_addr[i], e_data[i][11:0]});
        end
    endtask

    task automatic prep(input logic [31:0] ctl0, input bit h, input bit c, input bit v, input bit sl);
        @(negedge clk);
        ctl_init = ctl0; en_pc_hi = h; en_ctx = c; en_vm = v; slow = sl;
        e_n = 0;
        tb_clear = 1'b1;
        @(negedge clk);
        tb_clear = 1'b0;
    endtask

    task automatic run(input bit extra_start);
        int t;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (!done && t < 3000) begin
            @(negedge clk);
            t++;
            if (extra_start && t == 3) start = 1'b1;
            if (extra_start && t == 4) start = 1'b0;
        end
        if (t >= 3000) chk(1'b0, "watchdog", t, 0);
    endtask

    task automatic ex_prefix(input logic [31:0] ctl0);
        ex(1, 12'h300, 32'h0);
        ex(0, 12'h310, ctl0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(!bus_req && !busy && !done, "R1 idle bus", {bus_req, busy, done}, 0);
        chk(!snap_valid && !flag_timeout && !flag_noperm && !flag_prohib, "R1 flags",
            {snap_valid, flag_timeout, flag_noperm, flag_prohib}, 0);
        chk((pc_lo | pc_hi | ctx_id | vm_state | pwr_status) == 0, "R1 words",
            pc_lo | pc_hi | ctx_id | vm_state | pwr_status, 0);
    endtask

    task automatic t_normal(input bit twice);
        prep(32'hA0, 1, 1, 1, 0);
        stat_seq[0] = 32'h1; stat_seq[1] = 32'h1;
        v_pc = 32'h8000_1234; v_hi = 32'hFFFF_0001; v_ctx = 32'h55; v_vm = 32'h8000_0007;
        run(twice);
        chk(snap_valid && !flag_timeout && !flag_noperm && !flag_prohib, "R8 valid only",
            {snap_valid, flag_timeout, flag_noperm, flag_prohib}, 4'b1000);
        chk(pc_lo == 32'h8000_1234, "R7 pc_lo", pc_lo, 32'h8000_1234);
        chk(pc_hi == 32'hFFFF_0001, "R8 pc_hi", pc_hi, 32'hFFFF_0001);
        chk(ctx_id == 32'h55, "R8 ctx", ctx_id, 32'h55);
        chk(vm_state == 32'h8000_0007, "R8 vm", vm_state, 32'h8000_0007);
        @(negedge clk);
        chk(!done, "R9 done one cycle", done, 0);
        repeat (6) @(negedge clk);
        ex_prefix(32'hA0);
        ex(0, 12'h310, 32'hA0); ex(1, 12'h310, 32'hA8);
        ex(0, 12'h314, 32'h1);
        ex(0, 12'h310, 32'hA8); ex(1, 12'h310, 32'hA9);
        ex(0, 12'h314, 32'h1);
        ex(0, 12'h0A0, 0); ex(0, 12'h0AC, 0); ex(0, 12'h0A4, 0); ex(0, 12'h0A8, 0);
        ex(1, 12'h310, 32'hA0);
        if (twice) begin
            cmp_log("R11");
            chk(n_done == 1 && !busy, "R11 single done", n_done, 1);
        end else begin
            cmp_log("R2 R3 R5 R8 R9");
        end
    endtask

    task automatic t_slow_poll();
        prep(32'h30, 1, 0, 1, 1);
        stat_seq[0] = 32'h0; stat_seq[1] = 32'h0; stat_seq[2] = 32'h1; stat_seq[3] = 32'h1;
        v_pc = 32'h0000_4000; v_hi = 32'h7; v_ctx = 32'h99; v_vm = 32'h3;
        run(0);
        chk(snap_valid && ctx_id == 0, "R8 ctx skipped", ctx_id, 0);
        chk(pc_hi == 32'h7 && vm_state == 32'h3, "R8 hi vm", {pc_hi[15:0], vm_state[15:0]}, 32'h0007_0003);
        ex_prefix(32'h30);
        ex(0, 12'h310, 32'h30); ex(1, 12'h310, 32'h38);
        ex(0, 12'h314, 0); ex(0, 12'h314, 0); ex(0, 12'h314, 0);
        ex(0, 12'h310, 32'h38); ex(1, 12'h310, 32'h39);
        ex(0, 12'h314, 0);
        ex(0, 12'h0A0, 0); ex(0, 12'h0AC, 0); ex(0, 12'h0A8, 0);
        ex(1, 12'h310, 32'h30);
        cmp_log("R3 R8 R10 slow");
        if (log_n >= 7) begin
            chk(log_cyc[5] - log_cyc[4] >= GAP + 1, "R3 poll gap", log_cyc[5] - log_cyc[4], GAP + 1);
            chk(log_cyc[6] - log_cyc[5] >= GAP + 1, "R3 poll gap", log_cyc[6] - log_cyc[5], GAP + 1);
        end
    endtask

    task automatic t_timeout();
        prep(32'hA0, 1, 1, 1, 0);
        for (int i = 0; i < 16; i++) stat_seq[i] = 32'h0;
        run(0);
        chk(flag_timeout && !snap_valid && !flag_noperm && !flag_prohib, "R4 timeout flag",
            {snap_valid, flag_timeout, flag_noperm, flag_prohib}, 4'b0100);
        chk(pc_lo == 0, "R4 no pc read", pc_lo, 0);
        ex_prefix(32'hA0);
        ex(0, 12'h310, 32'hA0); ex(1, 12'h310, 32'hA8);
        for (int i = 0; i < MAXT; i++) ex(0, 12'h314, 0);
        ex(1, 12'h310, 32'hA0);
        cmp_log("R4 R9");
    endtask

    task automatic t_drop();
        prep(32'hA0, 0, 0, 0, 0);
        stat_seq[0] = 32'h1; stat_seq[1] = 32'h0; stat_seq[2] = 32'h1; stat_seq[3] = 32'h1;
        v_pc = 32'h1000;
        run(0);
        chk(snap_valid && pc_lo == 32'h1000, "R5 valid after retry", pc_lo, 32'h1000);
        ex_prefix(32'hA0);
        ex(0, 12'h310, 32'hA0); ex(1, 12'h310, 32'hA8); ex(0, 12'h314, 0);
        ex(0, 12'h310, 32'hA8); ex(1, 12'h310, 32'hA9); ex(0, 12'h314, 0);
        ex(0, 12'h310, 32'hA9); ex(1, 12'h310, 32'hA9); ex(0, 12'h314, 0);
        ex(0, 12'h310, 32'hA9); ex(1, 12'h310, 32'hA9); ex(0, 12'h314, 0);
        ex(0, 12'h0A0, 0);
        ex(1, 12'h310, 32'hA0);
        cmp_log("R5 retry");
    endtask

    task automatic t_noperm();
        prep(32'h4, 1, 1, 1, 0);
        stat_seq[0] = 32'h1; stat_seq[1] = 32'h41;
        run(0);
        chk(flag_noperm && !snap_valid && !flag_timeout && !flag_prohib, "R6 noperm flag",
            {snap_valid, flag_timeout, flag_noperm, flag_prohib}, 4'b0010);
        chk(pwr_status == 32'h41, "R6 status kept", pwr_status, 32'h41);
        ex_prefix(32'h4);
        ex(0, 12'h310, 32'h4); ex(1, 12'h310, 32'hC); ex(0, 12'h314, 0);
        ex(0, 12'h310, 32'hC); ex(1, 12'h310, 32'hD); ex(0, 12'h314, 0);
        ex(1, 12'h310, 32'h4);
        cmp_log("R6 R9");
    endtask

    task automatic t_prohib();
        prep(32'hA0, 1, 1, 1, 0);
        stat_seq[0] = 32'h1; stat_seq[1] = 32'h1;
        v_pc = 32'hFFFF_FFFF;
        run(0);
        chk(flag_prohib && !snap_valid && !flag_timeout && !flag_noperm, "R7 prohib flag",
            {snap_valid, flag_timeout, flag_noperm, flag_prohib}, 4'b0001);
        chk((pc_hi | ctx_id | vm_state) == 0, "R7 optional skipped", pc_hi | ctx_id | vm_state, 0);
        ex_prefix(32'hA0);
        ex(0, 12'h310, 32'hA0); ex(1, 12'h310, 32'hA8); ex(0, 12'h314, 0);
        ex(0, 12'h310, 32'hA8); ex(1, 12'h310, 32'hA9); ex(0, 12'h314, 0);
        ex(0, 12'h0A0, 0);
        ex(1, 12'h310, 32'hA0);
        cmp_log("R7 R9");
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_normal(0);
        t_slow_poll();
        t_timeout();
        t_drop();
        t_noperm();
        t_prohib();
        t_normal(1);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule